// File: doc/BRIEF.md
# Lockable flash timing clock divider

This block holds an 8-bit control register and a prescaler that turns the bus clock into a timing tick of about 1 MHz. Flash program and erase steps are timed from that tick. Software sets the tick period by writing a 6-bit divide value through a single-register port with a write strobe. A mode input selects normal or special operation. A command-busy input blocks register updates while a flash command is running.

In normal mode a one-time lock bit can freeze the divide value until the next reset. In special mode the lock and the divide value can be rewritten without limit. A sticky status flag records whether any write has been accepted since reset. The tick stays low until that flag is set, so flash timing cannot start from an unconfigured divider.

Top module: `flash_tick_divider`

## Requirements
- R1: After reset the register reads 0x00 and both `tick_o` and `configured_o` are low.
- R2: Bit 7 is the loaded flag. An accepted write sets it, whatever value `wr_data_i[7]` carries, and only reset clears it.
- R3: In normal mode (`special_mode_i`=0), bit 6 is the lock bit. A write can set it but cannot clear it.
- R4: In normal mode, while the lock bit is set, a write leaves the divide field (bits 5..0) unchanged. While the lock bit is clear, a write loads the divide field, including on the write that sets the lock.
- R5: In special mode (`special_mode_i`=1), a write copies `wr_data_i[6:0]` into bits 6..0, and can clear the lock. Bit 7 still follows R2 only.
- R6: A write presented while `busy_i`=1 is dropped. It changes no bit, including the loaded flag.
- R7: Once loaded, `tick_o` is a one-cycle pulse repeating every (divide value + 1) clock cycles. With divide value 0 it is high every cycle.
- R8: An accepted write that changes the divide field restarts the prescaler. The first tick comes in the (divide value + 1)th cycle after the write edge.
- R9: While the loaded flag is 0, `tick_o` stays low.
- R10: `rd_data_o` always shows {loaded, lock, divide} as held, in either mode. `configured_o` equals the loaded flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe, one per cycle |
| wr_data_i | input | 8 | Write data: bit 6 lock, bits 5..0 divide value |
| special_mode_i | input | 1 | 1 selects special mode, 0 selects normal mode |
| busy_i | input | 1 | Flash command running; writes are dropped |
| rd_data_o | output | 8 | Register read value |
| tick_o | output | 1 | Divided timing tick, one cycle wide |
| configured_o | output | 1 | Divider has been written since reset |

## Verification
A wrong register bit appears on `rd_data_o` in the first cycle after the faulty write edge. The bench reads the register back right after every write, so a broken lock, loaded or busy rule shows up at once. A prescaler fault, such as a missing restart, a wrong wrap point or a tick while unloaded, shows within one tick period. That period is at most 64 cycles, and the bench measures the distance from the write edge to the first tick and between later ticks.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;
  localparam int unsigned FDIV_W = 6;
  localparam int unsigned REG_W  = FDIV_W + 2;

  typedef struct packed {
    logic              loaded;
    logic              lock;
    logic [FDIV_W-1:0] div;
  } fdiv_reg_t;
endpackage

// File: rtl/fdiv_ctrl_reg.sv
module fdiv_ctrl_reg
  import fdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             special_mode_i,
  input  logic             busy_i,
  output fdiv_reg_t        reg_o,
  output logic             div_chg_o
);
  fdiv_reg_t q, d;
  logic      accept;

  assign accept = wr_en_i && !busy_i;

  always_comb begin
    d = q;
    if (accept) begin
      d.loaded = 1'b1;
      if (special_mode_i) begin
        d.lock = wr_data_i[FDIV_W];
        d.div  = wr_data_i[FDIV_W-1:0];
      end else begin
        d.lock = q.lock | wr_data_i[FDIV_W];
        // lock taken from the held value: a write may set lock and load div together
        if (!q.lock) d.div = wr_data_i[FDIV_W-1:0];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= d;
  end

  assign div_chg_o = accept && (d.div != q.div);
  assign reg_o     = q;
endmodule

// File: rtl/fdiv_prescaler.sv
module fdiv_prescaler #(
  parameter int unsigned CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic [CNT_W-1:0] div_i,
  input  logic             restart_i,
  output logic             tick_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap;

  assign wrap = (cnt_q == div_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (restart_i || !en_i || wrap) cnt_q <= '0;
    else                               cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = en_i && wrap;
endmodule

// File: rtl/flash_tick_divider.sv
module flash_tick_divider
  import fdiv_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_en_i,
  input  logic [REG_W-1:0] wr_data_i,
  input  logic             special_mode_i,
  input  logic             busy_i,
  output logic [REG_W-1:0] rd_data_o,
  output logic             tick_o,
  output logic             configured_o
);
  fdiv_reg_t reg_q;
  logic      div_chg;

  fdiv_ctrl_reg u_reg (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .wr_en_i        (wr_en_i),
    .wr_data_i      (wr_data_i),
    .special_mode_i (special_mode_i),
    .busy_i         (busy_i),
    .reg_o          (reg_q),
    .div_chg_o      (div_chg)
  );

  fdiv_prescaler #(.CNT_W(FDIV_W)) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .en_i      (reg_q.loaded),
    .div_i     (reg_q.div),
    .restart_i (div_chg),
    .tick_o    (tick_o)
  );

  assign rd_data_o    = reg_q;
  assign configured_o = reg_q.loaded;
endmodule

// File: rtl/fdiv_chk.sv
module fdiv_chk
  import fdiv_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic             special_mode_i,
  input logic             busy_i,
  input logic [REG_W-1:0] rd_data_o,
  input logic             tick_o
);
  assert_loaded_sticky_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_data_o[REG_W-1] |=> rd_data_o[REG_W-1]);

  assert_lock_held_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!special_mode_i && rd_data_o[FDIV_W]) |=> rd_data_o[FDIV_W]);

  assert_div_frozen_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!special_mode_i && rd_data_o[FDIV_W]) |=> $stable(rd_data_o[FDIV_W-1:0]));

  assert_busy_drop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> $stable(rd_data_o));

  assert_no_write_stable_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> $stable(rd_data_o));

  assert_tick_width_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && rd_data_o[FDIV_W-1:0] != '0 && !wr_en_i) |=> !tick_o);

  assert_tick_gated_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_data_o[REG_W-1] |-> !tick_o);
endmodule

bind flash_tick_divider fdiv_chk u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .wr_en_i        (wr_en_i),
  .special_mode_i (special_mode_i),
  .busy_i         (busy_i),
  .rd_data_o      (rd_data_o),
  .tick_o         (tick_o)
);

// File: tb/flash_tick_divider_test.sv
`timescale 1ns/1ps
module flash_tick_divider_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       special = 1'b0;
  logic       busy = 1'b0;
  logic [7:0] rd_data;
  logic       tick;
  logic       configured;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  flash_tick_divider uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .wr_en_i        (wr_en),
    .wr_data_i      (wr_data),
    .special_mode_i (special),
    .busy_i         (busy),
    .rd_data_o      (rd_data),
    .tick_o         (tick),
    .configured_o   (configured)
  );

  // {special, busy, write data, expected read}
  localparam int NV = 10;
  localparam logic [17:0] VEC [NV] = '{
    {1'b0, 1'b1, 8'h45, 8'h00},  // R6 dropped, loaded stays 0
    {1'b0, 1'b0, 8'h05, 8'h85},  // R2 loaded set by hardware
    {1'b0, 1'b0, 8'h8A, 8'h8A},  // R2 data bit 7 irrelevant
    {1'b0, 1'b0, 8'h43, 8'hC3},  // R4 lock and div together
    {1'b0, 1'b0, 8'h07, 8'hC3},  // R3 R4 lock holds, div frozen
    {1'b1, 1'b0, 8'h09, 8'h89},  // R5 lock cleared in special
    {1'b1, 1'b0, 8'h7F, 8'hFF},  // R5
    {1'b1, 1'b0, 8'h3F, 8'hBF},  // R5 bit 7 not cleared
    {1'b1, 1'b1, 8'h00, 8'hBF},  // R6 busy in special
    {1'b0, 1'b0, 8'h02, 8'h82}   // R10 readback
  };

  task automatic chk(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic sp, input logic bz, input logic [7:0] d);
    @(negedge clk);
    special = sp; busy = bz; wr_data = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0; busy = 1'b0;
  endtask

  // cycles from the current negedge (counted as 1) until tick is seen
  task automatic cycles_to_tick(output int n);
    n = 1;
    while (!tick && n < 200) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected under 20000", cycles);
      finish_run();
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rd_data, 8'h00, "R1 reset read");
    chk(tick, 0, "R1 reset tick");
    chk(configured, 0, "R1 R10 reset configured");
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    chk(tick, 0, "R9 unloaded tick");

    for (int i = 0; i < NV; i++) begin
      do_write(VEC[i][17], VEC[i][16], VEC[i][15:8]);
      chk(rd_data, VEC[i][7:0], $sformatf("R2 R3 R4 R5 R6 table[%0d]", i));
      chk(configured, VEC[i][7], $sformatf("R10 configured table[%0d]", i));
      if (i == 0) chk(tick, 0, "R9 tick after dropped write");
    end

    // R8 restart then R7 period, div=3
    do_write(1'b0, 1'b0, 8'h03);
    cycles_to_tick(n);
    chk(n, 4, "R8 first tick div3");
    @(negedge clk);
    chk(tick, 0, "R7 tick width");
    n = 1;
    while (!tick && n < 200) begin
      @(negedge clk);
      n++;
    end
    chk(n, 4, "R7 period div3");

    // R8 mid-count change to div=5
    @(negedge clk);
    do_write(1'b0, 1'b0, 8'h05);
    cycles_to_tick(n);
    chk(n, 6, "R8 first tick div5");
    @(negedge clk);
    cycles_to_tick(n);
    chk(n, 6, "R7 period div5");

    // R7 divide 0: tick every cycle
    do_write(1'b0, 1'b0, 8'h00);
    chk(tick, 1, "R7 div0 cycle1");
    @(negedge clk);
    chk(tick, 1, "R7 div0 cycle2");
    @(negedge clk);
    chk(tick, 1, "R7 div0 cycle3");

    // R6 busy write does not disturb tick or register
    do_write(1'b0, 1'b1, 8'h07);
    chk(rd_data, 8'h80, "R6 busy keeps register");
    chk(tick, 1, "R6 busy keeps div0 tick");

    // second reset, R9 with dropped write
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(rd_data, 8'h00, "R1 second reset read");
    rst_n = 1'b1;
    do_write(1'b0, 1'b1, 8'h01);
    chk(configured, 0, "R6 R10 busy leaves unconfigured");
    repeat (8) @(negedge clk);
    chk(tick, 0, "R9 still unloaded");

    finish_run();
  end
endmodule